// File: doc/BRIEF.md
# Dual-Core Atomic Lock Memory

This block is a small word-addressed memory shared by two cores. Each core has its own request channel. The block offers five operations: plain load, plain store, test-and-set, load-linked and store-conditional. Only one request is served per cycle. A two-state arbiter grants a lone requester at once. When both cores ask in the same cycle, the arbiter alternates between them. The granted operation reads and, where it applies, writes the array at the same clock edge. No other access can fall between the read and the write, so test-and-set and store-conditional are indivisible with respect to the other core.

Each core owns a link tracker. Load-linked arms the tracker with its address. Any committed write to that address clears it: a store, a test-and-set or a successful store-conditional, from either core. The core's own store-conditional also clears it. Software builds spinlocks on top of this. A word holding 0 is free and a word holding 1 is held. A lock is taken by test-and-set, or by a load-linked followed by a store-conditional, and it is released by a plain store of 0.

Three state machines shape the behaviour:
- **Arbiter.** States `TURN_C0` and `TURN_C1`. After any grant it moves to the turn of the core that was not served.
- **Link tracker.** States `LINK_NONE` and `LINK_ARMED`. The arm transition is taken on the core's own load-linked. The clear transition is taken on the core's own store-conditional or on a matching write.
- **Response stage.** States `RESP_QUIET` and `RESP_REPLY`. It enters `RESP_REPLY` on the edge after a grant and drops back to `RESP_QUIET` when no grant occurred.

Top module: `atomic_lock_mem`

## Requirements
- R1: After reset, with no requests, both grants and both response strobes are low, and the arbiter holds the core-0 turn.
- R2: Opcode encodings:
  - 0 is a load, returning the addressed word.
  - 1 is a store, writing the write data and returning 0.
  - Codes 5 to 7 act as loads and never write.
  
  The response strobe of the granted core rises exactly one cycle after its grant and stays low in every other cycle.
- R3: Test-and-set (opcode 2) returns the old word and leaves the value 1 in it. A later store of 0 lets the next test-and-set return 0 again.
- R4: Load-linked (opcode 3) returns the word and arms the issuing core's link with that address. A following store-conditional (opcode 4) to the same address writes its data and returns status 1. The status word always has every bit except bit 0 at zero.
- R5: A store-conditional with no armed link, or with a link on another address, returns status 0 and leaves memory unchanged.
- R6: A committed write to an address by either core disarms every link on that address. This covers a store, a test-and-set and a successful store-conditional.
- R7: A store-conditional disarms the issuing core's link whether it succeeds or fails, so an immediate second store-conditional returns 0.
- R8: At most one grant is given per cycle, and a lone requester is granted in the same cycle. When both cores request, the grant goes to the core not served by the previous grant.
- R9: A write to a different address leaves an armed link intact.
- R10: A grant is never given to a core that is not requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c0_req | input | 1 | Core 0 request |
| c0_op | input | 3 | Core 0 opcode |
| c0_addr | input | AW | Core 0 word address |
| c0_wdata | input | DATA_W | Core 0 write data |
| c0_gnt | output | 1 | Core 0 grant (combinational) |
| c0_rvalid | output | 1 | Core 0 response strobe |
| c0_rdata | output | DATA_W | Core 0 read data or status |
| c1_req | input | 1 | Core 1 request |
| c1_op | input | 3 | Core 1 opcode |
| c1_addr | input | AW | Core 1 word address |
| c1_wdata | input | DATA_W | Core 1 write data |
| c1_gnt | output | 1 | Core 1 grant (combinational) |
| c1_rvalid | output | 1 | Core 1 response strobe |
| c1_rdata | output | DATA_W | Core 1 read data or status |

## Verification
The atomic operations are exercised with several sequences, each aimed at a different fault:
- A load-linked/store-conditional pair with nothing in between separates a working link from a store-conditional that always fails.
- The same pair with a store, a test-and-set, or the other core's successful store-conditional in between shows whether foreign writes disarm the link. An unrelated-address write in between shows whether the address is compared at all.
- Back-to-back store-conditionals, and store-conditionals with no link or a link on another address, expose a link that survives its own use.
- Chained test-and-set and release patterns check the old-value return and the written 1.
- Held simultaneous requests check that the grant alternates rather than sticking to one core.

// File: rtl/atomic_pkg.sv
package atomic_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_TAS   = 3'd2,
        OP_LL    = 3'd3,
        OP_SC    = 3'd4
    } mem_op_e;

    typedef enum logic {
        TURN_C0 = 1'b0,
        TURN_C1 = 1'b1
    } turn_e;

    typedef enum logic {
        LINK_NONE  = 1'b0,
        LINK_ARMED = 1'b1
    } link_e;

    typedef enum logic {
        RESP_QUIET = 1'b0,
        RESP_REPLY = 1'b1
    } resp_e;

    localparam int NUM_CORES = 2;

endpackage

// File: rtl/rr_arbiter2.sv
module rr_arbiter2
    import atomic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req,
    output logic [1:0] gnt
);

    turn_e turn_q;
    turn_e turn_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            turn_q <= TURN_C0;
        end else begin
            turn_q <= turn_d;
        end
    end

    // grant and next turn
    always_comb begin
        gnt    = 2'b00;
        turn_d = turn_q;
        unique case (turn_q)
            TURN_C0: begin
                if (req[0]) begin
                    gnt = 2'b01;
                end else if (req[1]) begin
                    gnt = 2'b10;
                end
            end
            TURN_C1: begin
                if (req[1]) begin
                    gnt = 2'b10;
                end else if (req[0]) begin
                    gnt = 2'b01;
                end
            end
        endcase
        if (gnt[0]) begin
            turn_d = TURN_C1;
        end else if (gnt[1]) begin
            turn_d = TURN_C0;
        end
    end

endmodule

// File: rtl/link_tracker.sv
module link_tracker
    import atomic_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          own_sc,
    input  logic [AW-1:0] op_addr,
    input  logic          wr_commit,
    input  logic [AW-1:0] wr_addr,
    output logic          hit
);

    link_e         state_q;
    link_e         state_d;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINK_NONE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        hit     = 1'b0;
        unique case (state_q)
            LINK_NONE: begin
                if (arm) begin
                    state_d = LINK_ARMED;
                    addr_d  = op_addr;
                end
            end
            LINK_ARMED: begin
                hit = (addr_q == op_addr);
                if (arm) begin
                    addr_d = op_addr;
                end else if (own_sc) begin
                    state_d = LINK_NONE;
                end else if (wr_commit && (wr_addr == addr_q)) begin
                    state_d = LINK_NONE;
                end
            end
        endcase
    end

endmodule

// File: rtl/word_store.sv
module word_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/atomic_lock_mem.sv
module atomic_lock_mem
    import atomic_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c0_req,
    input  logic [2:0]        c0_op,
    input  logic [AW-1:0]     c0_addr,
    input  logic [DATA_W-1:0] c0_wdata,
    output logic              c0_gnt,
    output logic              c0_rvalid,
    output logic [DATA_W-1:0] c0_rdata,
    input  logic              c1_req,
    input  logic [2:0]        c1_op,
    input  logic [AW-1:0]     c1_addr,
    input  logic [DATA_W-1:0] c1_wdata,
    output logic              c1_gnt,
    output logic              c1_rvalid,
    output logic [DATA_W-1:0] c1_rdata
);

    logic [1:0]        gnt;
    logic              any_gnt;
    logic              sel;
    logic [2:0]        g_op;
    logic [AW-1:0]     g_addr;
    logic [DATA_W-1:0] g_wdata;
    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] new_word;
    logic              we;
    logic              sc_ok;
    logic [NUM_CORES-1:0] link_hit;

    rr_arbiter2 u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   ({c1_req, c0_req}),
        .gnt   (gnt)
    );

    assign c0_gnt  = gnt[0];
    assign c1_gnt  = gnt[1];
    assign any_gnt = |gnt;
    assign sel     = gnt[1];

    // operand selection from the granted core
    always_comb begin
        if (sel) begin
            g_op    = c1_op;
            g_addr  = c1_addr;
            g_wdata = c1_wdata;
        end else begin
            g_op    = c0_op;
            g_addr  = c0_addr;
            g_wdata = c0_wdata;
        end
    end

    // per-core link trackers
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_link
        link_tracker #(.AW(AW)) u_link (
            .clk       (clk),
            .rst_n     (rst_n),
            .arm       (gnt[i] && (g_op == OP_LL)),
            .own_sc    (gnt[i] && (g_op == OP_SC)),
            .op_addr   (g_addr),
            .wr_commit (we),
            .wr_addr   (g_addr),
            .hit       (link_hit[i])
        );
    end

    assign sc_ok = any_gnt && (g_op == OP_SC) && link_hit[sel];

    // write decision
    always_comb begin
        we       = 1'b0;
        new_word = g_wdata;
        if (any_gnt) begin
            unique case (g_op)
                OP_STORE: we = 1'b1;
                OP_TAS: begin
                    we       = 1'b1;
                    new_word = DATA_W'(1);
                end
                OP_SC:   we = sc_ok;
                default: we = 1'b0;
            endcase
        end
    end

    word_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (we),
        .addr  (g_addr),
        .wdata (new_word),
        .rdata (old_word)
    );

    // response stage
    resp_e             resp_q;
    resp_e             resp_d;
    logic              core_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] data_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= RESP_QUIET;
            core_q <= 1'b0;
            data_q <= '0;
        end else begin
            resp_q <= resp_d;
            core_q <= sel;
            data_q <= data_d;
        end
    end

    always_comb begin
        resp_d = any_gnt ? RESP_REPLY : RESP_QUIET;
        if (g_op == OP_STORE) begin
            data_d = '0;
        end else if (g_op == OP_SC) begin
            data_d = {{(DATA_W-1){1'b0}}, sc_ok};
        end else begin
            data_d = old_word;
        end
    end

    always_comb begin
        c0_rvalid = 1'b0;
        c1_rvalid = 1'b0;
        unique case (resp_q)
            RESP_QUIET: ;
            RESP_REPLY: begin
                c0_rvalid = !core_q;
                c1_rvalid = core_q;
            end
        endcase
        c0_rdata = c0_rvalid ? data_q : '0;
        c1_rdata = c1_rvalid ? data_q : '0;
    end

endmodule

// File: rtl/atomic_lock_mem_chk.sv
module atomic_lock_mem_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              c0_req,
    input logic [2:0]        c0_op,
    input logic              c0_gnt,
    input logic              c0_rvalid,
    input logic [DATA_W-1:0] c0_rdata,
    input logic              c1_req,
    input logic [2:0]        c1_op,
    input logic              c1_gnt,
    input logic              c1_rvalid,
    input logic [DATA_W-1:0] c1_rdata
);

    logic live_q;
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    p_single_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(c0_gnt && c1_gnt));

    p_gnt_has_req_c0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        c0_gnt |-> c0_req);

    p_gnt_has_req_c1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        c1_gnt |-> c1_req);

    p_lone_wins_c0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_req && !c1_req) |-> c0_gnt);

    p_lone_wins_c1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c1_req && !c0_req) |-> c1_gnt);

    p_alternate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && c0_req && c1_req && $past(c0_req && c1_req && c0_gnt)) |-> c1_gnt);

    p_reply_after_grant_c0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        c0_gnt |=> c0_rvalid);

    p_quiet_without_grant_c0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !c0_gnt |=> !c0_rvalid);

    p_reply_after_grant_c1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        c1_gnt |=> c1_rvalid);

    p_quiet_without_grant_c1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !c1_gnt |=> !c1_rvalid);

    p_sc_status_bit_c0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && c0_rvalid && $past(c0_gnt && (c0_op == 3'd4))) |-> (c0_rdata[DATA_W-1:1] == '0));

    p_sc_status_bit_c1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && c1_rvalid && $past(c1_gnt && (c1_op == 3'd4))) |-> (c1_rdata[DATA_W-1:1] == '0));

endmodule

bind atomic_lock_mem atomic_lock_mem_chk #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .c0_req    (c0_req),
    .c0_op     (c0_op),
    .c0_gnt    (c0_gnt),
    .c0_rvalid (c0_rvalid),
    .c0_rdata  (c0_rdata),
    .c1_req    (c1_req),
    .c1_op     (c1_op),
    .c1_gnt    (c1_gnt),
    .c1_rvalid (c1_rvalid),
    .c1_rdata  (c1_rdata)
);

// File: tb/test_atomic_lock_mem.sv
`timescale 1ns/1ps
module test_atomic_lock_mem;

    localparam int DW = 32;
    localparam int AW = 4;
    localparam logic [2:0] LD = 3'd0, ST = 3'd1, TS = 3'd2, LL = 3'd3, SC = 3'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          c0_req = 1'b0, c1_req = 1'b0;
    logic [2:0]    c0_op = '0, c1_op = '0;
    logic [AW-1:0] c0_addr = '0, c1_addr = '0;
    logic [DW-1:0] c0_wdata = '0, c1_wdata = '0;
    logic          c0_gnt, c1_gnt, c0_rvalid, c1_rvalid;
    logic [DW-1:0] c0_rdata, c1_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    atomic_lock_mem #(.DATA_W(DW), .DEPTH(16)) i_atomic_lock_mem (
        .clk(clk), .rst_n(rst_n),
        .c0_req(c0_req), .c0_op(c0_op), .c0_addr(c0_addr), .c0_wdata(c0_wdata),
        .c0_gnt(c0_gnt), .c0_rvalid(c0_rvalid), .c0_rdata(c0_rdata),
        .c1_req(c1_req), .c1_op(c1_op), .c1_addr(c1_addr), .c1_wdata(c1_wdata),
        .c1_gnt(c1_gnt), .c1_rvalid(c1_rvalid), .c1_rdata(c1_rdata)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one operation on one core, checks grant, latency and returned word
    task automatic run_op(input int core, input logic [2:0] op, input int addr,
                          input logic [DW-1:0] wd, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        if (core == 0) begin
            c0_req = 1'b1; c0_op = op; c0_addr = AW'(addr); c0_wdata = wd;
        end else begin
            c1_req = 1'b1; c1_op = op; c1_addr = AW'(addr); c1_wdata = wd;
        end
        #1;
        chk({tag, " R8 grant"}, DW'(core == 0 ? c0_gnt : c1_gnt), 1);
        chk({tag, " R2 no early strobe"}, DW'(core == 0 ? c0_rvalid : c1_rvalid), 0);
        @(negedge clk);
        c0_req = 1'b0; c1_req = 1'b0;
        chk({tag, " R2 strobe"}, DW'(core == 0 ? c0_rvalid : c1_rvalid), 1);
        chk({tag, " data"}, core == 0 ? c0_rdata : c1_rdata, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 c0 grant idle", DW'(c0_gnt), 0);
        chk("R1 c1 grant idle", DW'(c1_gnt), 0);
        chk("R1 c0 strobe idle", DW'(c0_rvalid), 0);
        chk("R1 c1 strobe idle", DW'(c1_rvalid), 0);
        chk("R10 no grant without request", DW'({c1_gnt, c0_gnt}), 0);
    endtask

    task automatic t_load_store();
        run_op(0, ST, 3, 32'hA5, 0, "R2 store");
        run_op(1, LD, 3, 0, 32'hA5, "R2 load other core");
        run_op(0, 3'd7, 3, 32'hFF, 32'hA5, "R2 code7 as load");
        run_op(1, 3'd5, 3, 32'h0, 32'hA5, "R2 code5 no write");
        @(negedge clk);
        chk("R2 strobe drops", DW'({c1_rvalid, c0_rvalid}), 0);
    endtask

    task automatic t_tas();
        run_op(0, ST, 5, 0, 0, "R3 init");
        run_op(0, TS, 5, 0, 0, "R3 tas free");
        run_op(1, TS, 5, 0, 1, "R3 tas held");
        run_op(1, LD, 5, 0, 1, "R3 word is one");
        run_op(0, ST, 5, 0, 0, "R3 release");
        run_op(1, TS, 5, 0, 0, "R3 tas after release");
    endtask

    task automatic t_llsc();
        run_op(0, ST, 2, 7, 0, "R4 init");
        run_op(0, LL, 2, 0, 7, "R4 ll");
        run_op(0, SC, 2, 9, 1, "R4 sc ok");
        run_op(1, LD, 2, 0, 9, "R4 written");
    endtask

    task automatic t_sc_fail();
        run_op(1, SC, 2, 33, 0, "R5 sc no link");
        run_op(0, LD, 2, 0, 9, "R5 unchanged");
        run_op(1, LL, 4, 0, 'x, "R5 ll elsewhere");
    endtask

    task automatic t_sc_fail_b();
        run_op(1, SC, 2, 44, 0, "R5 sc other addr");
        run_op(1, LD, 2, 0, 9, "R5 still unchanged");
    endtask

    task automatic t_clear_by_write();
        run_op(0, LL, 6, 0, 3, "R6 ll");
        run_op(1, ST, 6, 4, 0, "R6 foreign store");
        run_op(0, SC, 6, 8, 0, "R6 sc after store");
        run_op(0, LD, 6, 0, 4, "R6 mem kept");
        run_op(1, LL, 6, 0, 4, "R6 ll c1");
        run_op(0, TS, 6, 0, 4, "R6 foreign tas");
        run_op(1, SC, 6, 8, 0, "R6 sc after tas");
        run_op(1, LD, 6, 0, 1, "R6 tas value kept");
        run_op(0, LL, 6, 0, 1, "R6 ll race c0");
        run_op(1, LL, 6, 0, 1, "R6 ll race c1");
        run_op(1, SC, 6, 21, 1, "R6 sc c1 wins");
        run_op(0, SC, 6, 22, 0, "R6 sc c0 loses");
        run_op(0, LD, 6, 0, 21, "R6 winner value");
    endtask

    task automatic t_sc_clears_own();
        run_op(0, LL, 9, 0, 'x, "R7 ll");
        run_op(0, SC, 9, 5, 1, "R7 first sc");
        run_op(0, SC, 9, 6, 0, "R7 second sc");
        run_op(1, LD, 9, 0, 5, "R7 value");
    endtask

    task automatic t_unrelated_write();
        run_op(1, LL, 10, 0, 'x, "R9 ll");
        run_op(0, ST, 11, 77, 0, "R9 store elsewhere");
        run_op(0, TS, 12, 0, 'x, "R9 tas elsewhere");
        run_op(1, SC, 10, 66, 1, "R9 sc survives");
        run_op(0, LD, 10, 0, 66, "R9 value");
    endtask

    task automatic t_contend();
        run_op(1, ST, 13, 32'h22, 0, "R8 prep c1");
        run_op(0, ST, 12, 32'h11, 0, "R8 prep c0");
        @(negedge clk);
        c0_req = 1'b1; c0_op = LD; c0_addr = 4'd12;
        c1_req = 1'b1; c1_op = LD; c1_addr = 4'd13;
        #1;
        chk("R8 contend first to c1", DW'({c1_gnt, c0_gnt}), 2);
        @(negedge clk);
        chk("R8 contend second to c0", DW'({c1_gnt, c0_gnt}), 1);
        chk("R8 c1 strobe", DW'({c1_rvalid, c0_rvalid}), 2);
        chk("R8 c1 data", c1_rdata, 32'h22);
        @(negedge clk);
        c0_req = 1'b0; c1_req = 1'b0;
        chk("R8 c0 strobe", DW'({c1_rvalid, c0_rvalid}), 1);
        chk("R8 c0 data", c0_rdata, 32'h11);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_store();
        t_tas();
        t_llsc();
        t_sc_fail();
        t_sc_fail_b();
        run_op(0, ST, 6, 3, 0, "R6 init");
        t_clear_by_write();
        t_sc_clears_own();
        t_unrelated_write();
        t_contend();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule